// File: doc/BRIEF.md
# Mode-Aware x86 Opcode Classifier

The block takes x86 machine code one byte per clock and sorts each instruction from a small subset into an operation class. For each instruction it reports a destination register, an operand size and the total length in bytes. A mode input selects the legacy 32-bit decode or the 64-bit long-mode decode. Several byte values mean different things in the two modes. The row 0x40–0x4F is a one-byte register increment or decrement in 32-bit mode and a register-extension (REX) prefix in 64-bit mode. Opcode 0x63 adjusts a selector privilege field in 32-bit mode and sign-extends a doubleword in 64-bit mode. The decimal-adjust opcodes are rejected in long mode. The flag-byte transfers SAHF and LAHF are accepted in long mode only when a configuration input allows them.

A fetch unit or a trace checker drives `byte_valid_i`/`byte_i` whenever `byte_ready_o` is high. It reads one result on the cycle `done_o` pulses. Pending prefix state is local to one instruction, and the byte after the last byte of an instruction starts the next one.

Top module: `x86c_classifier`

## Requirements
- R1: In 32-bit mode (`mode64_i`=0), bytes 0x40–0x47 give class INC (1) and bytes 0x48–0x4F give class DEC (2). The register is byte[2:0], the size is 32 bits (code 2) or 16 bits (code 1) after a 0x66 prefix, and the length is 1 plus the number of prefixes.
- R2: In 64-bit mode, bytes 0x40–0x4F are a REX prefix and produce no result on their own. Bit 3 (W) selects 64-bit size (code 3). Bit 2 (R) becomes register bit 3 for the ModRM reg field. Bit 0 (B) becomes register bit 3 for the ModRM rm field and for the B8+r register.
- R3: A REX prefix counts only when the opcode follows it directly. A 0x66 that follows a REX byte cancels its W, R and B bits.
- R4: In both modes, 0xFF with ModRM mod=11 gives INC when reg=0 and DEC when reg=1, with register {B, rm}. Any other ModRM gives class INVALID (0) with length (prefixes + 2).
- R5: 0x63 with ModRM mod=11 gives ARPL (3) in 32-bit mode, with register rm and 16-bit size. In 64-bit mode it gives MOVSXD (4), with register {R, reg} and 64-bit size when W=1, otherwise 32-bit. Length is prefixes + 2. A ModRM with mod≠11 gives INVALID.
- R6: 0x27, 0x2F, 0x37 and 0x3F (length 1) and 0xD4 and 0xD5 (each with an imm8, length 2) give class BCD (7) in 32-bit mode. In 64-bit mode they give INVALID with length prefixes + 1.
- R7: 0x9E gives SAHF (5) and 0x9F gives LAHF (6), each with 8-bit size (code 0) and length 1. In 64-bit mode they are INVALID unless `lahf_ok_i`=1.
- R8: B8+r gives MOV_IMM (8) with register {B, r}. The immediate is 4 bytes, 2 bytes after 0x66, or 8 bytes with REX.W in 64-bit mode, and the size code follows the same choice.
- R9: 0xA1 gives MOV_ABS (9) with register 0. Its absolute address is 4 bytes in 32-bit mode and 8 bytes in 64-bit mode. The size is 64 bits with REX.W, otherwise 32 bits, or 16 bits after 0x66.
- R10: Any other opcode gives INVALID, register 0, size code 0 and length prefixes + 1.
- R11: `done_o` pulses for exactly one cycle, in the cycle after the clock edge that accepts an instruction's last byte. Cycles with `byte_valid_i` low consume nothing and do not break an instruction.
- R12: Reset clears pending prefixes and decode progress. It holds `done_o` and `byte_ready_o` low.
- R13: A prefix byte arriving when MAX_PFX prefixes are already pending ends the instruction as INVALID with length MAX_PFX + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode64_i | input | 1 | 1 = 64-bit long mode, 0 = 32-bit mode |
| lahf_ok_i | input | 1 | Accept SAHF/LAHF in long mode |
| byte_valid_i | input | 1 | Byte offered this cycle |
| byte_i | input | 8 | Instruction byte |
| byte_ready_o | output | 1 | Block accepts bytes |
| done_o | output | 1 | One-cycle result strobe |
| class_o | output | 4 | Operation class code |
| reg_o | output | 4 | Destination register number |
| size_o | output | 2 | Operand size: 0=8, 1=16, 2=32, 3=64 bits |
| len_o | output | LEN_W (4) | Instruction length in bytes |

## Verification
A stale prefix or a wrong decode state shows up at the very next result. If a REX or 0x66 bit leaks past the end of an instruction, the next instruction reports the wrong size or register. If the byte count is wrong, the tail of a long immediate is taken as a new opcode, and `done_o` then arrives a cycle early or late. Every sequence therefore checks that no strobe appears before the last byte. Sequences are also run back to back, with a reset in the middle and with idle gaps, so that leaked state cannot hide.

// File: rtl/x86c_pkg.sv
package x86c_pkg;

  typedef enum logic [3:0] {
    CLS_INVALID = 4'd0,
    CLS_INC     = 4'd1,
    CLS_DEC     = 4'd2,
    CLS_ARPL    = 4'd3,
    CLS_MOVSXD  = 4'd4,
    CLS_SAHF    = 4'd5,
    CLS_LAHF    = 4'd6,
    CLS_BCD     = 4'd7,
    CLS_MOV_IMM = 4'd8,
    CLS_MOV_ABS = 4'd9
  } cls_e;

  typedef enum logic [1:0] {SZ_8 = 2'd0, SZ_16 = 2'd1, SZ_32 = 2'd2, SZ_64 = 2'd3} osz_e;

  // which ModRM interpretation an opcode waits for
  typedef enum logic [1:0] {MR_NONE, MR_GRP5, MR_SX} mr_e;

  typedef enum logic [1:0] {ST_OP, ST_MODRM, ST_TAIL} st_e;

  typedef struct packed {
    logic osz16;
    logic rex_w;
    logic rex_r;
    logic rex_b;
  } pfx_t;

  function automatic osz_e op_size(input logic w, input logic o16);
    if (w)        return SZ_64;
    else if (o16) return SZ_16;
    else          return SZ_32;
  endfunction

endpackage

// File: rtl/x86c_opdec.sv
module x86c_opdec
  import x86c_pkg::*;
(
  input  logic [7:0] op_i,
  input  logic       mode64_i,
  input  logic       lahf_ok_i,
  input  logic       osz16_i,
  input  logic       rex_w_i,
  input  logic       rex_b_i,
  output cls_e       cls_o,
  output logic [3:0] reg_o,
  output osz_e       size_o,
  output mr_e        modrm_o,
  output logic [3:0] tail_o
);

  always_comb begin
    cls_o   = CLS_INVALID;
    reg_o   = 4'd0;
    size_o  = SZ_8;
    modrm_o = MR_NONE;
    tail_o  = 4'd0;
    casez (op_i)
      8'b0100_0???: if (!mode64_i) begin
        cls_o  = CLS_INC;
        reg_o  = {1'b0, op_i[2:0]};
        size_o = op_size(1'b0, osz16_i);
      end
      8'b0100_1???: if (!mode64_i) begin
        cls_o  = CLS_DEC;
        reg_o  = {1'b0, op_i[2:0]};
        size_o = op_size(1'b0, osz16_i);
      end
      8'hFF: modrm_o = MR_GRP5;
      8'h63: modrm_o = MR_SX;
      8'h27, 8'h2F, 8'h37, 8'h3F: if (!mode64_i) cls_o = CLS_BCD;
      8'hD4, 8'hD5: if (!mode64_i) begin
        cls_o  = CLS_BCD;
        tail_o = 4'd1;
      end
      8'h9E: if (!mode64_i || lahf_ok_i) cls_o = CLS_SAHF;
      8'h9F: if (!mode64_i || lahf_ok_i) cls_o = CLS_LAHF;
      8'b1011_1???: begin
        cls_o  = CLS_MOV_IMM;
        reg_o  = {rex_b_i, op_i[2:0]};
        size_o = op_size(rex_w_i, osz16_i);
        tail_o = rex_w_i ? 4'd8 : (osz16_i ? 4'd2 : 4'd4);
      end
      8'hA1: begin
        cls_o  = CLS_MOV_ABS;
        size_o = op_size(rex_w_i, osz16_i);
        tail_o = mode64_i ? 4'd8 : 4'd4;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/x86c_modrm.sv
module x86c_modrm
  import x86c_pkg::*;
(
  input  mr_e        kind_i,
  input  logic [7:0] modrm_i,
  input  logic       mode64_i,
  input  logic       osz16_i,
  input  logic       rex_w_i,
  input  logic       rex_r_i,
  input  logic       rex_b_i,
  output cls_e       cls_o,
  output logic [3:0] reg_o,
  output osz_e       size_o
);

  logic [1:0] md;
  logic [2:0] rg, rm;

  assign md = modrm_i[7:6];
  assign rg = modrm_i[5:3];
  assign rm = modrm_i[2:0];

  always_comb begin
    cls_o  = CLS_INVALID;
    reg_o  = 4'd0;
    size_o = SZ_8;
    if (md == 2'b11) begin
      unique case (kind_i)
        MR_GRP5: if (rg == 3'd0 || rg == 3'd1) begin
          cls_o  = (rg == 3'd0) ? CLS_INC : CLS_DEC;
          reg_o  = {rex_b_i, rm};
          size_o = op_size(rex_w_i, osz16_i);
        end
        MR_SX: if (mode64_i) begin
          cls_o  = CLS_MOVSXD;
          reg_o  = {rex_r_i, rg};
          size_o = op_size(rex_w_i, osz16_i);
        end else begin
          cls_o  = CLS_ARPL;
          reg_o  = {1'b0, rm};
          size_o = SZ_16;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/x86c_classifier.sv
module x86c_classifier
  import x86c_pkg::*;
#(
  parameter int MAX_PFX = 4,
  localparam int LEN_W  = $clog2(MAX_PFX + 11)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode64_i,
  input  logic             lahf_ok_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  output logic             byte_ready_o,
  output logic             done_o,
  output logic [3:0]       class_o,
  output logic [3:0]       reg_o,
  output logic [1:0]       size_o,
  output logic [LEN_W-1:0] len_o
);

  st_e              st_q;
  pfx_t             pfx_q;
  mr_e              kind_q;
  logic [LEN_W-1:0] cnt_q;
  logic [3:0]       tail_q;
  cls_e             hold_cls_q, cls_q;
  logic [3:0]       hold_reg_q, reg_q;
  osz_e             hold_size_q, size_q;
  logic             ready_q, done_q;
  logic [LEN_W-1:0] len_q;

  logic take, is_osz, is_rex, is_pfx;
  assign take   = byte_valid_i && ready_q;
  assign is_osz = (byte_i == 8'h66);
  assign is_rex = mode64_i && (byte_i[7:4] == 4'h4);
  assign is_pfx = is_osz || is_rex;

  cls_e       dec_cls, mr_cls;
  logic [3:0] dec_reg, mr_reg, dec_tail;
  osz_e       dec_size, mr_size;
  mr_e        dec_mr;

  x86c_opdec u_opdec (
    .op_i      (byte_i),
    .mode64_i  (mode64_i),
    .lahf_ok_i (lahf_ok_i),
    .osz16_i   (pfx_q.osz16),
    .rex_w_i   (pfx_q.rex_w),
    .rex_b_i   (pfx_q.rex_b),
    .cls_o     (dec_cls),
    .reg_o     (dec_reg),
    .size_o    (dec_size),
    .modrm_o   (dec_mr),
    .tail_o    (dec_tail)
  );

  x86c_modrm u_modrm (
    .kind_i   (kind_q),
    .modrm_i  (byte_i),
    .mode64_i (mode64_i),
    .osz16_i  (pfx_q.osz16),
    .rex_w_i  (pfx_q.rex_w),
    .rex_r_i  (pfx_q.rex_r),
    .rex_b_i  (pfx_q.rex_b),
    .cls_o    (mr_cls),
    .reg_o    (mr_reg),
    .size_o   (mr_size)
  );

  // instruction completes on this byte
  logic       fin;
  cls_e       fin_cls;
  logic [3:0] fin_reg;
  osz_e       fin_size;

  always_comb begin
    fin      = 1'b0;
    fin_cls  = CLS_INVALID;
    fin_reg  = 4'd0;
    fin_size = SZ_8;
    if (take) begin
      unique case (st_q)
        ST_OP: begin
          if (is_pfx) begin
            fin = (cnt_q == LEN_W'(MAX_PFX));
          end else if (dec_mr == MR_NONE && dec_tail == 4'd0) begin
            fin      = 1'b1;
            fin_cls  = dec_cls;
            fin_reg  = dec_reg;
            fin_size = dec_size;
          end
        end
        ST_MODRM: begin
          fin      = 1'b1;
          fin_cls  = mr_cls;
          fin_reg  = mr_reg;
          fin_size = mr_size;
        end
        ST_TAIL: begin
          fin      = (tail_q == 4'd1);
          fin_cls  = hold_cls_q;
          fin_reg  = hold_reg_q;
          fin_size = hold_size_q;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_OP;
      pfx_q       <= '0;
      kind_q      <= MR_NONE;
      cnt_q       <= '0;
      tail_q      <= '0;
      hold_cls_q  <= CLS_INVALID;
      hold_reg_q  <= '0;
      hold_size_q <= SZ_8;
      cls_q       <= CLS_INVALID;
      reg_q       <= '0;
      size_q      <= SZ_8;
      len_q       <= '0;
      done_q      <= 1'b0;
      ready_q     <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      done_q  <= 1'b0;
      if (fin) begin
        cls_q  <= fin_cls;
        reg_q  <= fin_reg;
        size_q <= fin_size;
        len_q  <= cnt_q + 1'b1;
        done_q <= 1'b1;
        cnt_q  <= '0;
        pfx_q  <= '0;
        st_q   <= ST_OP;
      end else if (take) begin
        cnt_q <= cnt_q + 1'b1;
        unique case (st_q)
          ST_OP: begin
            if (is_osz) begin
              pfx_q <= '{osz16: 1'b1, rex_w: 1'b0, rex_r: 1'b0, rex_b: 1'b0};
            end else if (is_rex) begin
              pfx_q.rex_w <= byte_i[3];
              pfx_q.rex_r <= byte_i[2];
              pfx_q.rex_b <= byte_i[0];
            end else if (dec_mr != MR_NONE) begin
              kind_q <= dec_mr;
              st_q   <= ST_MODRM;
            end else begin
              hold_cls_q  <= dec_cls;
              hold_reg_q  <= dec_reg;
              hold_size_q <= dec_size;
              tail_q      <= dec_tail;
              st_q        <= ST_TAIL;
            end
          end
          ST_TAIL: tail_q <= tail_q - 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign byte_ready_o = ready_q;
  assign done_o       = done_q;
  assign class_o      = cls_q;
  assign reg_o        = reg_q;
  assign size_o       = size_q;
  assign len_o        = len_q;

  AST_PFX_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_OP |-> cnt_q <= LEN_W'(MAX_PFX)); // R13

  AST_LEGACY_INCDEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && st_q == ST_OP && !mode64_i && byte_i[7:4] == 4'h4
    |=> done_o && (class_o == CLS_INC || class_o == CLS_DEC)); // R1

  AST_REX_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && st_q == ST_OP && mode64_i && byte_i[7:4] == 4'h4 && cnt_q < LEN_W'(MAX_PFX)
    |=> !done_o); // R2

  AST_BCD_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && st_q == ST_OP && mode64_i && (byte_i inside {8'h27, 8'h2F, 8'h37, 8'h3F, 8'hD4, 8'hD5})
    |=> done_o && class_o == CLS_INVALID); // R6

  AST_FLAGBYTE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && st_q == ST_OP && mode64_i && !lahf_ok_i && (byte_i inside {8'h9E, 8'h9F})
    |=> done_o && class_o == CLS_INVALID); // R7

  AST_IMM64_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && class_o == CLS_MOV_IMM && size_o == SZ_64 |-> len_o >= LEN_W'(10)); // R8

endmodule

// File: tb/sim_x86c_classifier.sv
module sim_x86c_classifier;
  import x86c_pkg::*;

  localparam int MAX_PFX = 4;
  localparam int LEN_W   = $clog2(MAX_PFX + 11);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mode64 = 1'b0, lahf_ok = 1'b0, bvalid = 1'b0;
  logic [7:0]       bdata = 8'h00;
  logic             ready, done;
  logic [3:0]       cls, rg;
  logic [1:0]       sz;
  logic [LEN_W-1:0] len;

  always #5 clk = ~clk;

  x86c_classifier #(.MAX_PFX(MAX_PFX)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode64_i(mode64), .lahf_ok_i(lahf_ok),
    .byte_valid_i(bvalid), .byte_i(bdata), .byte_ready_o(ready), .done_o(done),
    .class_o(cls), .reg_o(rg), .size_o(sz), .len_o(len)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] seq[$];
  bit finished = 0;

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // feed seq, then check the single result
  task automatic run(string rq, int e_cls, int e_reg, int e_sz, int e_len, bit gap = 0);
    int early = 0;
    foreach (seq[i]) begin
      @(negedge clk);
      if (i > 0 && done) early++;
      bvalid = 1'b1;
      bdata  = seq[i];
      @(posedge clk);
      if (gap && i < seq.size() - 1) begin
        @(negedge clk);
        if (done) early++;
        bvalid = 1'b0;
        @(posedge clk);
      end
    end
    @(negedge clk);
    bvalid = 1'b0;
    chk(early == 0, rq, "early done", early, 0);
    chk(done == 1'b1, rq, "done", int'(done), 1);
    chk(int'(cls) == e_cls, rq, "class", int'(cls), e_cls);
    chk(int'(rg) == e_reg, rq, "reg", int'(rg), e_reg);
    chk(int'(sz) == e_sz, rq, "size", int'(sz), e_sz);
    chk(int'(len) == e_len, rq, "len", int'(len), e_len);
    seq.delete();
  endtask

  task automatic set_mode(bit m64, bit lok);
    @(negedge clk);
    mode64  = m64;
    lahf_ok = lok;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(ready == 1'b0, "R12", "ready in reset", int'(ready), 0);
    chk(done == 1'b0, "R12", "done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R12", "ready after reset", int'(ready), 1);
  endtask

  task automatic t_legacy_incdec();
    set_mode(0, 0);
    seq = '{8'h40};               run("R1", CLS_INC, 0, SZ_32, 1);
    seq = '{8'h4F};               run("R1", CLS_DEC, 7, SZ_32, 1);
    seq = '{8'h66, 8'h43};        run("R1", CLS_INC, 3, SZ_16, 2);
  endtask

  task automatic t_rex();
    set_mode(1, 0);
    seq = '{8'h48, 8'hFF, 8'hC0}; run("R2", CLS_INC, 0, SZ_64, 3);
    seq = '{8'h41, 8'hFF, 8'hC9}; run("R2", CLS_DEC, 9, SZ_32, 3);
    // REX then 0x66: REX dropped
    seq = '{8'h48, 8'h66, 8'hFF, 8'hC0}; run("R3", CLS_INC, 0, SZ_16, 4);
    seq = '{8'h41, 8'h66, 8'hB8, 8'h01, 8'h02}; run("R3", CLS_MOV_IMM, 0, SZ_16, 5);
  endtask

  task automatic t_grp5();
    set_mode(0, 0);
    seq = '{8'hFF, 8'hC8}; run("R4", CLS_DEC, 0, SZ_32, 2);
    seq = '{8'hFF, 8'hD0}; run("R4", CLS_INVALID, 0, SZ_8, 2);
    set_mode(1, 0);
    seq = '{8'hFF, 8'hC0}; run("R4", CLS_INC, 0, SZ_32, 2);
    seq = '{8'hFF, 8'h00}; run("R4", CLS_INVALID, 0, SZ_8, 2);
  endtask

  task automatic t_sx();
    set_mode(0, 0);
    seq = '{8'h63, 8'hC1};        run("R5", CLS_ARPL, 1, SZ_16, 2);
    set_mode(1, 0);
    seq = '{8'h48, 8'h63, 8'hC1}; run("R5", CLS_MOVSXD, 0, SZ_64, 3);
    seq = '{8'h4C, 8'h63, 8'hD8}; run("R5", CLS_MOVSXD, 11, SZ_64, 3);
    seq = '{8'h63, 8'hC8};        run("R5", CLS_MOVSXD, 1, SZ_32, 2);
    seq = '{8'h63, 8'h08};        run("R5", CLS_INVALID, 0, SZ_8, 2);
  endtask

  task automatic t_bcd();
    set_mode(0, 0);
    seq = '{8'h27};        run("R6", CLS_BCD, 0, SZ_8, 1);
    seq = '{8'hD4, 8'h0A}; run("R6", CLS_BCD, 0, SZ_8, 2);
    set_mode(1, 0);
    seq = '{8'h37};        run("R6", CLS_INVALID, 0, SZ_8, 1);
    seq = '{8'hD5};        run("R6", CLS_INVALID, 0, SZ_8, 1);
  endtask

  task automatic t_flagbyte();
    set_mode(0, 0);
    seq = '{8'h9E}; run("R7", CLS_SAHF, 0, SZ_8, 1);
    set_mode(1, 1);
    seq = '{8'h9F}; run("R7", CLS_LAHF, 0, SZ_8, 1);
    set_mode(1, 0);
    seq = '{8'h9F}; run("R7", CLS_INVALID, 0, SZ_8, 1);
    seq = '{8'h9E}; run("R7", CLS_INVALID, 0, SZ_8, 1);
  endtask

  task automatic t_movimm();
    set_mode(0, 0);
    seq = '{8'hBA, 8'h11, 8'h22, 8'h33, 8'h44}; run("R8", CLS_MOV_IMM, 2, SZ_32, 5);
    seq = '{8'h66, 8'hB8, 8'h11, 8'h22};        run("R8", CLS_MOV_IMM, 0, SZ_16, 4);
    set_mode(1, 0);
    seq = '{8'h49, 8'hBF, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08};
    run("R8", CLS_MOV_IMM, 15, SZ_64, 10);
    seq = '{8'hB9, 8'h01, 8'h02, 8'h03, 8'h04}; run("R8", CLS_MOV_IMM, 1, SZ_32, 5);
  endtask

  task automatic t_movabs();
    set_mode(0, 0);
    seq = '{8'hA1, 8'h00, 8'h10, 8'h00, 8'h00}; run("R9", CLS_MOV_ABS, 0, SZ_32, 5);
    set_mode(1, 0);
    seq = '{8'h48, 8'hA1, 8'h1, 8'h2, 8'h3, 8'h4, 8'h5, 8'h6, 8'h7, 8'h8};
    run("R9", CLS_MOV_ABS, 0, SZ_64, 10);
    seq = '{8'hA1, 8'h1, 8'h2, 8'h3, 8'h4, 8'h5, 8'h6, 8'h7, 8'h8};
    run("R9", CLS_MOV_ABS, 0, SZ_32, 9);
  endtask

  task automatic t_undef();
    set_mode(0, 0);
    seq = '{8'h90};        run("R10", CLS_INVALID, 0, SZ_8, 1);
    set_mode(1, 0);
    seq = '{8'h66, 8'h90}; run("R10", CLS_INVALID, 0, SZ_8, 2);
    seq = '{8'h48, 8'h0F}; run("R10", CLS_INVALID, 0, SZ_8, 2);
  endtask

  task automatic t_pfx_cap();
    set_mode(0, 0);
    seq = '{8'h66, 8'h66, 8'h66, 8'h66, 8'h66}; run("R13", CLS_INVALID, 0, SZ_8, MAX_PFX + 1);
    set_mode(1, 0);
    seq = '{8'h40, 8'h66, 8'h42, 8'h66, 8'h48}; run("R13", CLS_INVALID, 0, SZ_8, MAX_PFX + 1);
    seq = '{8'h66, 8'h66, 8'h66, 8'h48, 8'hB8, 1, 2, 3, 4, 5, 6, 7, 8};
    run("R13", CLS_MOV_IMM, 0, SZ_64, 13);
  endtask

  task automatic t_pulse_gap();
    set_mode(0, 0);
    seq = '{8'hBB, 8'h01, 8'h02, 8'h03, 8'h04}; run("R11", CLS_MOV_IMM, 3, SZ_32, 5, 1);
    @(negedge clk);
    chk(done == 1'b0, "R11", "single pulse", int'(done), 1'b0);
    set_mode(1, 0);
    seq = '{8'h48, 8'hFF, 8'hC8}; run("R11", CLS_DEC, 0, SZ_64, 3, 1);
    // next instruction must not inherit REX.W
    seq = '{8'hFF, 8'hC8};        run("R11", CLS_DEC, 0, SZ_32, 2);
  endtask

  task automatic t_mid_reset();
    set_mode(1, 0);
    @(negedge clk);
    bvalid = 1'b1;
    bdata  = 8'h4F;
    @(negedge clk);
    bvalid = 1'b0;
    rst_n  = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R12", "done during reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    seq = '{8'hFF, 8'hC0}; run("R12", CLS_INC, 0, SZ_32, 2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_legacy_incdec();
    t_rex();
    t_grp5();
    t_sx();
    t_bcd();
    t_flagbyte();
    t_movimm();
    t_movabs();
    t_undef();
    t_pfx_cap();
    t_pulse_gap();
    t_mid_reset();
    repeat (2) @(negedge clk);
    report();
  end

endmodule